// File: doc/BRIEF.md
# I2C Serial EEPROM Read Engine

This block is the target-side read path of a two-wire serial EEPROM with a 2048-byte array. It watches the clock and data lines of an I2C bus, resynchronises them to the system clock, detects START and STOP conditions, and decodes the device address byte. Data leaves the block through an open-drain model: `sda_oe` high pulls the data line low. The array sits outside the block and is reached through a synchronous byte-wide read port. The port is addressed by an internal 11-bit current-address counter, and its data is valid one clock after the address.

Three reads are supported. A current-address read returns the byte the counter points to. A random read first sends a write-direction device byte and a word address, which only loads the counter, and then issues a repeated START with a read-direction device byte. In a sequential read, the controller acknowledges each byte and receives the next one. The counter runs across the whole array and wraps from the top location to zero. Write programming is not part of this block. A write-direction transfer can only set the counter.

Top module: `eeprom_i2c_reader`

## Requirements
- R1: Reset state. After reset, `sda_oe` is low and `mem_addr` is 0.
- R2: START and STOP. A fall of SDA while SCL is high starts a new transfer, including a repeated START in the middle of a transfer. A rise of SDA while SCL is high returns the block to idle with SDA released.
- R3: Device byte matching. The device byte is received MSB first. Its bits 7:4 must equal 1010, in which case the block pulls SDA low during the ninth clock. On a mismatch the block gives no acknowledge and drives nothing until the next START.
- R4: Current-address read. Bit 0 of the device byte is the direction, and 1 means read. After the acknowledge, the block sends the byte at the current counter value, MSB first. The block-select bits of a read-direction device byte are ignored.
- R5: Dummy write. When the direction bit is 0, device-byte bits 3:1 form address bits 10:8. The next byte is acknowledged as address bits 7:0 and loaded into the counter. Any further byte in that transfer gets no acknowledge, and the array is never written.
- R6: Random read. A repeated START followed by a read-direction device byte, sent after a dummy write, returns the byte at the loaded address.
- R7: Sequential read. If the controller acknowledges a data byte (SDA low in the ninth clock), the block sends the byte at the next address. If it does not acknowledge, the block releases SDA and waits in idle.
- R8: Address counter. The counter increments after every byte sent, whether or not it is acknowledged, and wraps from 2047 to 0. A later current-address read continues from there.
- R9: SDA timing. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous to `clk` |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| mem_addr | output | 11 | Array read address (current-address counter) |
| mem_rdata | input | 8 | Array read data, valid one clock after `mem_addr` |

## Verification
The bench acts as the bus controller and is tried with four kinds of traffic: single current-address reads, random reads through a dummy write and a repeated START, acknowledged multi-byte bursts, and bursts that cross address 2047. Together these separate counter loading, counter stepping and wrap from a plain data path. A device byte with the wrong type nibble, and a dummy write followed by an extra data byte, show that the block stays silent when it should. The current-address read that follows each of these shows that the counter and the array were left alone. On every clock the bench also checks that the drive enable moves only while SCL is low.

// File: rtl/eeprom_i2c_reader.sv
module eeprom_i2c_reader #(
  parameter int          ADDR_W = 11,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  localparam int BLK_W = ADDR_W - 8;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_DEV    = 4'd1,
    S_DEVCHK = 4'd2,
    S_ACKD   = 4'd3,
    S_WORD   = 4'd4,
    S_WORDCHK= 4'd5,
    S_ACKW   = 4'd6,
    S_TX     = 4'd7,
    S_MACK   = 4'd8,
    S_MACK2  = 4'd9
  } state_t;

  state_t            st;
  logic [2:0]        scl_p, sda_p;
  logic [2:0]        bitn;
  logic [7:0]        shreg;
  logic              rw, mack;
  logic [BLK_W-1:0]  blk;
  logic [ADDR_W-1:0] addr;

  wire scl_s    = scl_p[1];
  wire scl_d    = scl_p[2];
  wire sda_s    = sda_p[1];
  wire sda_d    = sda_p[2];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  assign mem_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitn   <= '0;
      shreg  <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      blk    <= '0;
      addr   <= '0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= S_DEV;
      bitn   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WORD: if (scl_rise) begin
          shreg <= {shreg[6:0], sda_s};
          bitn  <= bitn + 3'd1;
          if (bitn == 3'd7) st <= (st == S_DEV) ? S_DEVCHK : S_WORDCHK;
        end
        S_DEVCHK: if (scl_fall) begin
          if (shreg[7:4] == DEV_ID) begin
            sda_oe <= 1'b1;
            rw     <= shreg[0];
            if (!shreg[0]) blk <= shreg[BLK_W:1];
            st     <= S_ACKD;
          end else begin
            st <= S_IDLE;
          end
        end
        S_ACKD: if (scl_fall) begin
          bitn <= '0;
          if (rw) begin
            shreg  <= mem_rdata;
            sda_oe <= ~mem_rdata[7];
            st     <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_WORD;
          end
        end
        S_WORDCHK: if (scl_fall) begin
          sda_oe <= 1'b1;
          addr   <= {blk, shreg};
          st     <= S_ACKW;
        end
        S_ACKW: if (scl_fall) begin
          sda_oe <= 1'b0;
          st     <= S_IDLE;
        end
        S_TX: if (scl_fall) begin
          if (bitn == 3'd7) begin
            sda_oe <= 1'b0;
            addr   <= addr + 1'b1;
            st     <= S_MACK;
          end else begin
            bitn   <= bitn + 3'd1;
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
          end
        end
        S_MACK: if (scl_rise) begin
          mack <= ~sda_s;
          st   <= S_MACK2;
        end
        S_MACK2: if (scl_fall) begin
          if (mack) begin
            shreg  <= mem_rdata;
            sda_oe <= ~mem_rdata[7];
            bitn   <= '0;
            st     <= S_TX;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_i2c_reader_chk.sv
module eeprom_i2c_reader_chk #(
  parameter int         ADDR_W = 11,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        st,
  input logic              scl_fall,
  input logic [3:0]        id_rx
);
  localparam logic [3:0] C_IDLE   = 4'd0;
  localparam logic [3:0] C_DEVCHK = 4'd2;
  localparam logic [3:0] C_TX     = 4'd7;
  localparam logic [3:0] C_MACK   = 4'd8;

  assert_oe_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE) |-> !sda_oe);

  assert_bad_id_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DEVCHK && scl_fall && id_rx != DEV_ID) |=> !sda_oe);

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_TX && st == C_MACK) |-> mem_addr == $past(mem_addr) + 1'b1);
endmodule

bind eeprom_i2c_reader eeprom_i2c_reader_chk #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .mem_addr(mem_addr), .st(st), .scl_fall(scl_fall), .id_rx(shreg[7:4])
);

// File: tb/eeprom_i2c_reader_bench.sv
module eeprom_i2c_reader_bench;
  localparam int Q = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [10:0] mem_addr;
  logic [7:0]  mem_rdata;
  wire         sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int model_addr = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  eeprom_i2c_reader u_eeprom_i2c_reader (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] memf(input int a);
    logic [10:0] x;
    x = a[10:0];
    return x[7:0] ^ {x[10:8], x[10:8], x[10:9]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) mem_rdata <= memf(int'(mem_addr));

  always @(posedge clk) begin
    #1;
    if (rst_n && sda_oe !== oe_prev) begin
      checks++;
      if (scl) begin
        errors++;
        $display("FAIL R9 drive changed with SCL high: actual oe=%0b expected oe=%0b", sda_oe, oe_prev);
      end
    end
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b, output logic got);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(Q);
    got = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic g;
    for (int i = 7; i >= 0; i--) send_bit(v[i], g);
    send_bit(1'b1, g);
    check(g == ~exp_ack, tag, int'(g), int'(~exp_ack));
  endtask

  task automatic read_byte(input logic give_ack, input string tag);
    logic g;
    logic [7:0] v;
    logic [7:0] e;
    e = memf(model_addr);
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, g);
      v[i] = g;
    end
    model_addr = (model_addr + 1) % 2048;
    send_bit(~give_ack, g);
    check(v == e, tag, int'(v), int'(e));
  endtask

  task automatic set_addr(input int a);
    bus_start();
    write_byte({4'b1010, a[10:8], 1'b0}, 1'b1, "R3 device ack (write)");
    write_byte(a[7:0], 1'b1, "R5 word address ack");
    model_addr = a;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      report();
    end
  end

  initial begin
    tick(4);
    check(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
    check(mem_addr == 11'd0, "R1 reset mem_addr", int'(mem_addr), 0);
    rst_n = 1'b1;
    tick(4);

    // R4 current-address read from 0, NoACK then STOP (R7)
    bus_start();
    write_byte(8'hA1, 1'b1, "R3 device ack (read)");
    read_byte(1'b0, "R4 current read data");
    bus_stop();
    tick(Q);
    check(sda_oe == 1'b0, "R2 released after stop", int'(sda_oe), 0);

    // R6 random read at 0x3C5, read device byte carries other block bits
    set_addr(11'h3C5);
    bus_start();
    write_byte(8'hAF, 1'b1, "R2 repeated start device ack");
    read_byte(1'b0, "R6 random read data");
    bus_stop();

    // R7 sequential burst continues from 0x3C6 (R8)
    bus_start();
    write_byte(8'hA1, 1'b1, "R3 device ack (read)");
    for (int k = 0; k < 4; k++) read_byte(1'b1, "R7 sequential data");
    read_byte(1'b0, "R7 last data");
    bus_stop();

    // R3 wrong type nibble: no ack, line stays released
    begin
      logic g;
      logic all1;
      bus_start();
      write_byte(8'hB1, 1'b0, "R3 mismatched id not acked");
      all1 = 1'b1;
      for (int k = 0; k < 9; k++) begin
        send_bit(1'b1, g);
        all1 &= g;
      end
      check(all1, "R3 silent after mismatch", int'(all1), 1);
      bus_stop();
    end
    bus_start();
    write_byte(8'hA1, 1'b1, "R3 device ack (read)");
    read_byte(1'b0, "R8 counter kept after mismatch");
    bus_stop();

    // R5 dummy write with extra data byte: not acked, no array change
    set_addr(11'h010);
    write_byte(8'h77, 1'b0, "R5 data byte not acked");
    bus_stop();
    bus_start();
    write_byte(8'hA1, 1'b1, "R3 device ack (read)");
    read_byte(1'b0, "R5 array and counter intact");
    bus_stop();

    // R8 wrap from 2047 to 0 during a burst, then continue with current read
    set_addr(11'h7FE);
    bus_start();
    write_byte(8'hA1, 1'b1, "R2 repeated start device ack");
    for (int k = 0; k < 3; k++) read_byte(1'b1, "R8 wrap burst data");
    read_byte(1'b0, "R8 wrap burst last");
    bus_stop();
    bus_start();
    write_byte(8'hA1, 1'b1, "R3 device ack (read)");
    read_byte(1'b0, "R8 continue after wrap");
    bus_stop();
    tick(Q);
    check(mem_addr == 11'd3, "R8 counter after reads", int'(mem_addr), 3);

    done = 1;
    report();
  end
endmodule